// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register side of a 24-pin general-purpose I/O port. A host reaches it through a byte-wide interface with an address, write data, a write strobe, a read strobe and a registered read-data bus. The pins are split into three groups of eight. Pin n belongs to group n/8 at bit n%8. Every register kind has one byte per group, and group k sits at the kind's base address plus k.

Each pin has four stored bits: a direction bit, a type bit, a pull-select bit and an output latch. A single write can never overwrite the output latch. The latch changes only through a set register, where each 1 raises a bit, and a clear register, where each 1 drops a bit. So several agents can each own a few pins without a read-modify-write race. The block decodes the direction, type and pull bits of each pin into controls for the pad models: output enable, open-drain, pull-up enable, pull-down enable and analog mode. The type and pull bits mean different things for output pins and for input pins. The pin inputs pass through a two-flop synchroniser and can be read back as state registers.

Top module: `gpx_port_bank`

## Requirements
- R1: Pin n maps to group n/8, bit n%8, and group k of each register kind is at that kind's base address plus k. A write to one group leaves the other groups of the same kind unchanged.
- R2: Reset clears every direction, type, pull and output latch bit, and it clears read data to 0x00. After reset every pin is an input in analog mode, with output enable, open-drain and both pulls low.
- R3: A write to a set register at 0x6C..0x6E sets the output latch bits where the data has a 1. Latch bits where the data has a 0 keep their value.
- R4: A write to a clear register at 0x70..0x72 clears the output latch bits where the data has a 1. Latch bits where the data has a 0 keep their value.
- R5: A read of either the set register or the clear register of a group returns that group's output latch. The latch drives pin_out directly, and the latch holds its value whenever no set or clear write targets its group.
- R6: The direction bytes at 0x60..0x62, the type bytes at 0x64..0x66 and the pull-select bytes at 0x68..0x6A are read/write and read back the value last written. In the direction byte, 1 means output and 0 means input.
- R7: An output pin always has output enable set and never has pull-down enabled.
  - With type 0 the pin is push-pull: open-drain is 0 and pull-up is 0, whatever the pull-select bit holds.
  - With type 1 the pin is open-drain, and pull-up equals the pull-select bit.
- R8: An input pin has output enable and open-drain low.
  - With type 1, pull-select 1 enables pull-up and pull-select 0 enables pull-down.
  - With type 0 both pulls are off. Pull-select 1 gives a floating input and pull-select 0 sets pad_ana.
- R9: The state bytes at 0x10..0x12 return the synchronised pin inputs. A pin change made before clock edge t shows up in a read captured at edge t+2 or later, and a read captured at edge t or t+1 returns the old value. Writes to these addresses have no effect.
- R10: Reads of any unmapped address return 0x00. Writes to unmapped addresses change nothing.
- R11: reg_rdata loads on the rising edge where reg_rd is high, and it holds its value while reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_rd | input | 1 | Read strobe, sampled on the rising edge |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 24 | Asynchronous pin levels from the pads |
| pin_out | output | 24 | Output latch value for each pin |
| pad_oe | output | 24 | Output enable for each pin |
| pad_od | output | 24 | Open-drain mode for each pin |
| pad_pu | output | 24 | Pull-up enable for each pin |
| pad_pd | output | 24 | Pull-down enable for each pin |
| pad_ana | output | 24 | Analog mode for each input pin |

## Verification
A write sampled at a rising edge changes the stored bits, pin_out and the pad controls right after that edge. The bench drives on falling edges and checks each write's effect at the next falling edge, one edge later. A read returns data one edge after its strobe is sampled, so each read check samples reg_rdata at the falling edge after its capture edge. For the synchroniser, the bench holds the state-register read strobe high across the pin change. It expects the old byte at the first two capture edges and the new byte at the third, which pins the latency at exactly two flops.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  localparam int ADDR_W = 8;

  // Base address of each register kind; group k sits at base + k
  localparam logic [ADDR_W-1:0] A_STATE = 8'h10;
  localparam logic [ADDR_W-1:0] A_DIR   = 8'h60;
  localparam logic [ADDR_W-1:0] A_TYPE  = 8'h64;
  localparam logic [ADDR_W-1:0] A_PULL  = 8'h68;
  localparam logic [ADDR_W-1:0] A_SET   = 8'h6C;
  localparam logic [ADDR_W-1:0] A_CLR   = 8'h70;

  typedef struct packed {
    logic oe;
    logic od;
    logic pu;
    logic pd;
    logic ana;
  } pad_ctl_t;

  // Exact address match for group k of a register kind
  function automatic logic reg_hit(input logic [ADDR_W-1:0] addr,
                                   input logic [ADDR_W-1:0] base,
                                   input int k);
    return addr == (base + ADDR_W'(k));
  endfunction

  // Address falls inside the n groups of a register kind
  function automatic logic in_group(input logic [ADDR_W-1:0] addr,
                                    input logic [ADDR_W-1:0] base,
                                    input int n);
    logic [ADDR_W-1:0] off;
    off = addr - base;
    return (addr >= base) && (int'(off) < n);
  endfunction

  function automatic logic addr_mapped(input logic [ADDR_W-1:0] addr, input int n);
    return in_group(addr, A_STATE, n) || in_group(addr, A_DIR, n) ||
           in_group(addr, A_TYPE, n)  || in_group(addr, A_PULL, n) ||
           in_group(addr, A_SET, n)   || in_group(addr, A_CLR, n);
  endfunction

  // Per-pin pad control; the type and pull bits depend on direction
  function automatic pad_ctl_t pad_decode(input logic dir, input logic typ, input logic pul);
    pad_ctl_t c;
    c = '0;
    if (dir) begin
      c.oe = 1'b1;
      c.od = typ;
      c.pu = typ & pul;
    end else if (typ) begin
      c.pu = pul;
      c.pd = ~pul;
    end else begin
      c.ana = ~pul;
    end
    return c;
  endfunction

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [1:0]   age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

  // Edges since reset, saturating; lets the latency check avoid the reset window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R9
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpx_cfg_bank.sv
module gpx_cfg_bank
  import gpx_pkg::*;
#(
  parameter int DW = 8,
  parameter int K  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     dir_q,
  output logic [DW-1:0]     typ_q,
  output logic [DW-1:0]     pul_q,
  output logic [DW-1:0]     lat_q
);

  logic dir_hit, typ_hit, pul_hit, set_hit, clr_hit;

  assign dir_hit = wr_en && reg_hit(addr, A_DIR,  K);
  assign typ_hit = wr_en && reg_hit(addr, A_TYPE, K);
  assign pul_hit = wr_en && reg_hit(addr, A_PULL, K);
  assign set_hit = wr_en && reg_hit(addr, A_SET,  K);
  assign clr_hit = wr_en && reg_hit(addr, A_CLR,  K);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      typ_q <= '0;
      pul_q <= '0;
    end else begin
      if (dir_hit) dir_q <= wdata;
      if (typ_hit) typ_q <= wdata;
      if (pul_hit) pul_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_q <= '0;
    else if (set_hit) lat_q <= lat_q | wdata;
    else if (clr_hit) lat_q <= lat_q & ~wdata;
  end

  // R3
  set_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> (((lat_q & $past(wdata)) == $past(wdata)) &&
                 ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata)))));

  // R4
  clr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (((lat_q & $past(wdata)) == '0) &&
                 ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata)))));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(lat_q));

endmodule

// File: rtl/gpx_pad_decode.sv
module gpx_pad_decode
  import gpx_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0] dir,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pul,
  output logic [W-1:0] oe,
  output logic [W-1:0] od,
  output logic [W-1:0] pu,
  output logic [W-1:0] pd,
  output logic [W-1:0] ana
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    pad_ctl_t c;
    assign c      = pad_decode(dir[i], typ[i], pul[i]);
    assign oe[i]  = c.oe;
    assign od[i]  = c.od;
    assign pu[i]  = c.pu;
    assign pd[i]  = c.pd;
    assign ana[i] = c.ana;
  end

endmodule

// File: rtl/gpx_port_bank.sv
module gpx_port_bank
  import gpx_pkg::*;
#(
  parameter int BANKS = 3,
  parameter int DW    = 8,
  localparam int PINS = BANKS * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DW-1:0]     reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_od,
  output logic [PINS-1:0]   pad_pu,
  output logic [PINS-1:0]   pad_pd,
  output logic [PINS-1:0]   pad_ana
);

  logic [PINS-1:0] dir_all, typ_all, pul_all, lat_all, pin_state;
  logic [DW-1:0]   rd_mux;
  logic            rd_unmapped;

  gpx_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_state)
  );

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    gpx_cfg_bank #(.DW(DW), .K(k)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .dir_q (dir_all[k*DW +: DW]),
      .typ_q (typ_all[k*DW +: DW]),
      .pul_q (pul_all[k*DW +: DW]),
      .lat_q (lat_all[k*DW +: DW])
    );
  end

  gpx_pad_decode #(.W(PINS)) u_pad (
    .dir(dir_all), .typ(typ_all), .pul(pul_all),
    .oe(pad_oe), .od(pad_od), .pu(pad_pu), .pd(pad_pd), .ana(pad_ana)
  );

  assign pin_out = lat_all;

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < BANKS; k++) begin
      if (reg_hit(reg_addr, A_STATE, k)) rd_mux = pin_state[k*DW +: DW];
      if (reg_hit(reg_addr, A_DIR,   k)) rd_mux = dir_all[k*DW +: DW];
      if (reg_hit(reg_addr, A_TYPE,  k)) rd_mux = typ_all[k*DW +: DW];
      if (reg_hit(reg_addr, A_PULL,  k)) rd_mux = pul_all[k*DW +: DW];
      if (reg_hit(reg_addr, A_SET,   k)) rd_mux = lat_all[k*DW +: DW];
      if (reg_hit(reg_addr, A_CLR,   k)) rd_mux = lat_all[k*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign rd_unmapped = reg_rd && !addr_mapped(reg_addr, BANKS);

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> (reg_rdata == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R7
  od_only_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_od & ~dir_all) == '0) && ((pad_oe ^ dir_all) == '0));

  // R8
  pd_only_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pd & dir_all) == '0) && ((pad_pu & pad_pd) == '0));

endmodule

// File: tb/test_gpx_port_bank.sv
module test_gpx_port_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [23:0] pin_in = '0;
  logic [23:0] pin_out, pad_oe, pad_od, pad_pu, pad_pd, pad_ana;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpx_port_bank i_gpx_port_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_ana(pad_ana)
  );

  // {write addr, write data, read addr, expected read}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    32'h6CA5_6CA5, 32'h6C0A_6CAF, 32'h7081_6C2E, 32'h7000_702E,
    32'h6DFF_71FF, 32'h72F0_6E00, 32'h6E3C_723C, 32'h60F0_60F0,
    32'h655A_655A, 32'h6AC3_6AC3, 32'h63FF_6300, 32'h6112_60F0,
    32'h10FF_1000
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 1:    return "R3 set";
      2, 3, 5: return "R4 clear";
      4, 11:   return "R1 group select";
      6:       return "R5 latch readback";
      7, 8, 9: return "R6 config readback";
      10:      return "R10 unmapped";
      default: return "R9 state write ignored";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    check("R2 rdata", 32'(reg_rdata), 32'h0);
    check("R2 pin_out", 32'(pin_out), 32'h0);
    check("R2 oe", 32'(pad_oe), 32'h0);
    check("R2 pulls", 32'(pad_pu | pad_pd | pad_od), 32'h0);
    check("R2 analog", 32'(pad_ana), 32'hFFFFFF);
    do_rd(8'h60, rv); check("R2 dir", 32'(rv), 32'h0);
    do_rd(8'h6C, rv); check("R2 latch", 32'(rv), 32'h0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i][31:24], VEC[i][23:16]);
      do_rd(VEC[i][15:8], rv);
      check(vec_tag(i), 32'(rv), 32'(VEC[i][7:0]));
    end
    // R5 latch on pins: groups {3C, FF, 2E}
    check("R5 pin_out", 32'(pin_out), 32'h3CFF2E);
    // R1 dir bytes F0 (group 0) and 12 (group 1)
    check("R1 oe map", 32'(pad_oe), 32'h0012F0);

    // R2 reset clears the latch again
    do_reset();
    do_rd(8'h6E, rv); check("R2 latch after reset", 32'(rv), 32'h0);

    // R7 / R8 decode, group 0 pins (dir,typ,pul):
    // p0 100 p1 110 p2 101 p3 111 p4 000 p5 010 p6 001 p7 011
    do_wr(8'h60, 8'h0F);
    do_wr(8'h64, 8'hAA);
    do_wr(8'h68, 8'hCC);
    check("R7 oe", 32'(pad_oe), 32'h00000F);
    check("R7 od", 32'(pad_od), 32'h00000A);
    check("R7 R8 pu", 32'(pad_pu), 32'h000088);
    check("R8 pd", 32'(pad_pd), 32'h000020);
    check("R8 ana", 32'(pad_ana), 32'hFFFF10);

    // R9 synchroniser latency: read strobe held across the pin change
    @(negedge clk);
    pin_in = 24'hABCDEF; reg_addr = 8'h10; reg_rd = 1'b1;
    @(negedge clk); check("R9 edge t", 32'(reg_rdata), 32'h0);
    @(negedge clk); check("R9 edge t+1", 32'(reg_rdata), 32'h0);
    @(negedge clk); check("R9 edge t+2", 32'(reg_rdata), 32'hEF);
    reg_rd = 1'b0;
    do_rd(8'h11, rv); check("R9 group 1", 32'(rv), 32'hCD);
    do_rd(8'h12, rv); check("R9 group 2", 32'(rv), 32'hAB);

    // R11 hold while strobe low
    @(negedge clk);
    reg_addr = 8'h60; pin_in = '0;
    repeat (4) @(negedge clk);
    check("R11 hold", 32'(reg_rdata), 32'hAB);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule